// File: doc/BRIEF.md
# Segmented Multi-Event Capture Buffer

This block records a probe bus into an on-chip sample memory that is split into a power-of-two number of equal windows. After it is armed, every trigger pulse that arrives while the block is waiting starts filling the next free window with a run of consecutive samples, one per rising clock edge. A recurring event, such as repeated reads of one address, is therefore recorded many times in a single run, and the block does not have to be armed again between events. The run ends by itself once the last window is full.

The trigger is a single pulse that an external matcher supplies. The number of windows is chosen at arm time as a base-2 exponent. The window length is the total depth divided by the window count. While windows are filling, the number of completed windows is reported. The stored samples are read back through a synchronous port that takes a window index and an offset within that window.

Top module: `seg_capture`

## Requirements
- R1: After reset, `done`, `busy` and `seg_count` are all zero.
- R2: A high `arm` at a clock edge latches `seg_log2`, with values above log2(DEPTH) clamped to log2(DEPTH). The same edge clears `done` and `seg_count` and makes the block wait for a trigger. `arm` takes priority over `trig`.
- R3: With latched exponent k, the memory holds 2^k windows, and each window is DEPTH/2^k samples long.
- R4: A high `trig` at an edge while waiting stores `probe` from that edge at offset 0 of window `seg_count`. The next DEPTH/2^k − 1 edges store offsets 1, 2 and onward, with no gaps.
- R5: A `trig` that arrives while a window is filling is ignored. It neither restarts nor lengthens the window.
- R6: `seg_count` rises by exactly one at the edge that stores the last sample of a window.
- R7: At the edge that stores the last sample of the final window, `done` goes high and `seg_count` equals 2^k. After that, triggers are ignored, and neither the memory nor `seg_count` changes until the next `arm`.
- R8: Triggers that arrive before the first `arm` after reset are ignored.
- R9: `rd_data` presents the sample stored at window `rd_seg`, offset `rd_off`, one clock after these two inputs are applied. The offset is taken modulo the window length.
- R10: `busy` is high from the edge after a window's first sample up to and including the cycle of its last sample. A window of one sample never raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Starts a run and latches the window exponent |
| trig | input | 1 | Single-level trigger pulse from the matcher |
| seg_log2 | input | $clog2($clog2(DEPTH)+1) | Base-2 exponent of the window count |
| probe | input | DW | Data sampled on every capture edge |
| rd_seg | input | $clog2(DEPTH) | Window index for readout |
| rd_off | input | $clog2(DEPTH) | Sample offset within the window for readout |
| rd_data | output | DW | Registered readout sample |
| busy | output | 1 | A window is filling |
| done | output | 1 | All windows of the run are full |
| seg_count | output | $clog2(DEPTH)+1 | Number of completed windows |

## Verification
The probe is driven with a free-running count, so every stored sample identifies the exact edge on which it was taken. Reading back each window therefore shows both its start edge and whether any samples are missing. Every window exponent of a 16-deep configuration is swept, from one 16-sample window down to sixteen 1-sample windows. The idle gaps between triggers vary, which separates correct window placement from a fixed cadence. In each window an extra trigger is pulsed during the fill, and further triggers are pulsed before arming and after completion. Any restart or extra capture would shift the read-back counts or `seg_count` away from the values computed arithmetically.

// File: rtl/seg_capture_pkg.sv
package seg_capture_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FILL = 2'd2
  } cap_state_t;
endpackage

// File: rtl/seg_capture_ctrl.sv
module seg_capture_ctrl
  import seg_capture_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          trig,
  input  logic [SW-1:0] seg_log2,
  output logic          wr_en,
  output logic [AW-1:0] wr_seg,
  output logic [AW-1:0] wr_off,
  output logic [SW-1:0] cfg_q,
  output logic [AW:0]   seg_count,
  output logic          busy,
  output logic          done
);
  localparam logic [SW-1:0] AW_S = SW'(AW);
  localparam logic [AW:0]   DEPTH_V = (AW+1)'(DEPTH);

  cap_state_t    state_q;
  logic [AW-1:0] off_q;
  logic [AW:0]   count_q;
  logic          done_q;
  logic [AW:0]   len_v;
  logic [AW:0]   nseg_v;
  logic          cap;
  logic          last_off;
  logic [AW:0]   count_nx;

  always_comb begin
    len_v    = DEPTH_V >> cfg_q;
    nseg_v   = (AW+1)'(1) << cfg_q;
    cap      = (state_q == ST_FILL) || ((state_q == ST_WAIT) && trig);
    last_off = ({1'b0, off_q} == (len_v - (AW+1)'(1)));
    count_nx = count_q + (AW+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
      cfg_q   <= '0;
    end else if (arm) begin
      cfg_q   <= (seg_log2 > AW_S) ? AW_S : seg_log2;
      off_q   <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
      state_q <= ST_WAIT;
    end else if (cap) begin
      if (last_off) begin
        off_q   <= '0;
        count_q <= count_nx;
        if (count_nx == nseg_v) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          state_q <= ST_WAIT;
        end
      end else begin
        off_q   <= off_q + AW'(1);
        state_q <= ST_FILL;
      end
    end
  end

  assign wr_en     = cap && !arm;
  assign wr_seg    = count_q[AW-1:0];
  assign wr_off    = off_q;
  assign seg_count = count_q;
  assign busy      = (state_q == ST_FILL);
  assign done      = done_q;
endmodule

// File: rtl/seg_capture_map.sv
module seg_capture_map #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(AW + 1)
) (
  input  logic [SW-1:0] cfg,
  input  logic [AW-1:0] seg,
  input  logic [AW-1:0] off,
  output logic [AW-1:0] addr
);
  localparam logic [SW-1:0] AW_S = SW'(AW);
  localparam logic [AW:0]   DEPTH_V = (AW+1)'(DEPTH);

  logic [AW:0]   len_v;
  logic [AW-1:0] mask;
  logic [AW-1:0] base;

  always_comb begin
    len_v = DEPTH_V >> cfg;
    mask  = AW'(len_v - (AW+1)'(1));
    base  = seg << (AW_S - cfg);
    addr  = base | (off & mask);
  end
endmodule

// File: rtl/seg_capture_ram.sv
module seg_capture_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seg_capture.sv
module seg_capture #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          trig,
  input  logic [SW-1:0] seg_log2,
  input  logic [DW-1:0] probe,
  input  logic [AW-1:0] rd_seg,
  input  logic [AW-1:0] rd_off,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic [AW:0]   seg_count
);
  logic          wr_en;
  logic [AW-1:0] wr_seg;
  logic [AW-1:0] wr_off;
  logic [SW-1:0] cfg_q;
  logic [AW-1:0] addr_w [2];
  logic [AW-1:0] seg_in [2];
  logic [AW-1:0] off_in [2];

  seg_capture_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .arm(arm), .trig(trig), .seg_log2(seg_log2),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_off(wr_off), .cfg_q(cfg_q),
    .seg_count(seg_count), .busy(busy), .done(done)
  );

  assign seg_in[0] = wr_seg;
  assign off_in[0] = wr_off;
  assign seg_in[1] = rd_seg;
  assign off_in[1] = rd_off;

  for (genvar p = 0; p < 2; p++) begin : g_map
    seg_capture_map #(.DEPTH(DEPTH)) map_i (
      .cfg(cfg_q), .seg(seg_in[p]), .off(off_in[p]), .addr(addr_w[p])
    );
  end

  seg_capture_ram #(.DEPTH(DEPTH), .DW(DW)) ram_i (
    .clk(clk), .we(wr_en), .waddr(addr_w[0]), .wdata(probe),
    .raddr(addr_w[1]), .rdata(rd_data)
  );
endmodule

// File: rtl/seg_capture_chk.sv
module seg_capture_chk #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(AW + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic          trig,
  input logic          busy,
  input logic          done,
  input logic [AW:0]   seg_count,
  input logic [SW-1:0] cfg_q
);
  logic [AW:0] nseg_c;
  assign nseg_c = (AW+1)'(1) << cfg_q;

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!done && !busy && seg_count == '0));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (seg_count == $past(seg_count) ||
              seg_count == $past(seg_count) + (AW+1)'(1)));

  assert_done_full_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> seg_count == nseg_c);

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !arm) |=> (done && $stable(seg_count)));

  assert_busy_excl_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_fill_ignores_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && trig && !arm) |=> (seg_count == $past(seg_count) || !busy));
endmodule

bind seg_capture seg_capture_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .arm(arm), .trig(trig), .busy(busy),
  .done(done), .seg_count(seg_count), .cfg_q(cfg_q)
);

// File: tb/seg_capture_tb_top.sv
`timescale 1ns/1ps
module seg_capture_tb_top;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int SW    = $clog2(AW + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arm = 1'b0;
  logic          trig = 1'b0;
  logic [SW-1:0] seg_log2 = '0;
  logic [DW-1:0] probe = '0;
  logic [AW-1:0] rd_seg = '0;
  logic [AW-1:0] rd_off = '0;
  logic [DW-1:0] rd_data;
  logic          busy;
  logic          done;
  logic [AW:0]   seg_count;

  int n_tests = 0;
  int n_fail  = 0;
  int base [DEPTH];

  always #2.5 clk = ~clk;
  always @(negedge clk) probe <= probe + 8'd1;

  seg_capture #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .arm(arm), .trig(trig), .seg_log2(seg_log2),
    .probe(probe), .rd_seg(rd_seg), .rd_off(rd_off), .rd_data(rd_data),
    .busy(busy), .done(done), .seg_count(seg_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R1 done", int'(done), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 seg_count", int'(seg_count), 0);
    // R8: triggers before arm
    trig = 1'b1; tick(); trig = 1'b0; repeat (3) tick();
    check("R8 seg_count", int'(seg_count), 0);
    check("R8 busy", int'(busy), 0);
    check("R8 done", int'(done), 0);

    for (int k = 0; k <= AW; k++) begin
      int nseg;
      int len;
      nseg = 1 << k;
      len  = DEPTH >> k;
      seg_log2 = SW'(k);
      arm = 1'b1; tick(); arm = 1'b0;
      check("R2 done cleared", int'(done), 0);
      check("R2 count cleared", int'(seg_count), 0);
      for (int s = 0; s < nseg; s++) begin
        repeat (2 + s % 3) tick();
        trig = 1'b1;
        base[s] = int'(probe);
        tick();
        check("R10 busy after first sample", int'(busy), (len > 1) ? 1 : 0);
        trig = (len >= 2) ? 1'b1 : 1'b0; // R5: trigger during fill
        tick();
        trig = 1'b0;
        if (len > 2) repeat (len - 2) tick();
        check("R6 seg_count", int'(seg_count), s + 1);
        check("R10 busy after window", int'(busy), 0);
      end
      check("R7 done", int'(done), 1);
      check("R7 seg_count full", int'(seg_count), nseg);
      // R7: triggers after completion ignored
      trig = 1'b1; tick(); trig = 1'b0; repeat (len + 2) tick();
      check("R7 count held", int'(seg_count), nseg);
      check("R7 done held", int'(done), 1);
      // R3 R4 R5 R9: read back every window
      for (int s = 0; s < nseg; s++) begin
        for (int o = 0; o < len; o++) begin
          rd_seg = AW'(s);
          rd_off = AW'(o);
          tick();
          check($sformatf("R4 R9 k=%0d seg=%0d off=%0d", k, s, o),
                int'(rd_data), (base[s] + o) & 255);
        end
      end
      if (len > 1) begin
        rd_seg = '0;
        rd_off = AW'(len); // R9: offset wraps within window
        tick();
        check("R9 offset modulo", int'(rd_data), base[0] & 255);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule